// File: doc/BRIEF.md
# User Interrupt Posting Sequencer

This block posts a user interrupt to a target thread in a fixed sequence of steps. When software starts an operation with a table index, the block checks that the feature is usable in the current core context and that the index lies inside the configured table. It then reads one 16-byte entry from the target table. If the entry is usable, the block performs a locked read-modify-write of the posted-interrupt descriptor that the entry points to. In that update it marks the requested vector as pending. It also decides whether the receiving side must be notified. When a notification is needed, it raises an ordinary interprocessor interrupt request. That request carries the descriptor's notification vector and a destination ID shaped for the current APIC addressing mode.

Only one operation is in flight at a time. `busy` stays high from acceptance until the end of the operation. The end is marked by a one-cycle pulse on exactly one of `done` or `fault`. Memory is reached through a single 128-bit request/acknowledge port. A request is held until it is acknowledged, and the acknowledge may arrive in the same cycle as the request. A lock flag travels with the descriptor read and the descriptor write.

Top module: `uipi_post_seq`

## Requirements
- R1: If any of `feat_en`, `tt_en`, `long_mode` is 0 or `in_enclave` is 1 when `start` is accepted, the operation ends with `fault`=1 and `fault_ud`=1 (invalid opcode), and no memory request is made.
- R2: Otherwise, if `index` > `tbl_size`, the operation ends with `fault`=1 and `fault_ud`=0 (general protection), and no memory request is made. An index equal to `tbl_size` is allowed.
- R3: The first memory access is an unlocked read at address `tbl_base + index*16`. The address is held stable until `mem_ack`.
- R4: The entry layout is: valid at bit 0, reserved bits [7:1], user vector at [15:8], descriptor address at [127:64]. If the valid bit is 0 or any reserved bit is 1, the operation ends with a general-protection fault after that single access.
- R5: The descriptor is read with `mem_lock`=1 at the address taken from the entry. If descriptor bits [15:2] or [31:24] are nonzero, the operation ends with a general-protection fault, no write is issued, and the lock is dropped.
- R6: The written descriptor equals the read descriptor with pending bit 64+uv[5:0] set. uv[5:0] is the low six bits of the entry's user vector. All other bits are kept, except for the rule in R7.
- R7: With outstanding-notify at bit 0 and suppress-notify at bit 1: if both are 0, bit 0 is set in the write-back and a notification is raised. Otherwise bit 0 is unchanged and no notification is raised. `ipi_valid` pulses only together with `done`.
- R8: The descriptor write-back is issued with `mem_we`=1 and `mem_lock`=1. The lock is low whenever the block is idle.
- R9: With `apic_x2`=1, the notification carries `ipi_vec` = descriptor[23:16] and `ipi_dest` = descriptor[63:32].
- R10: With `apic_x2`=0, `ipi_dest` = {24'b0, descriptor[47:40]}, which is bits [15:8] of the destination field.
- R11: After reset the block is idle with `done`, `fault` and `mem_req` low. `start` is ignored while `busy` is 1. Each accepted operation ends with exactly one one-cycle pulse of `done` or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| index | input | IW | Target table index |
| tbl_base | input | AW | Target table base address |
| tbl_size | input | IW | Highest legal index |
| feat_en | input | 1 | Feature enabled |
| tt_en | input | 1 | Target table enabled |
| long_mode | input | 1 | Core in 64-bit mode |
| in_enclave | input | 1 | Core executing in an enclave |
| apic_x2 | input | 1 | 1: 32-bit destination mode, 0: 8-bit mode |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Faulting completion pulse |
| fault_ud | output | 1 | With `fault`: 1 invalid opcode, 0 general protection |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Request is part of the locked update |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 128 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 128 | Read data |
| ipi_valid | output | 1 | Notification request pulse |
| ipi_vec | output | 8 | Notification vector |
| ipi_dest | output | 32 | Destination APIC ID |

## Verification
Two events can coincide. First, a new `start` can arrive in the same cycle that the previous operation's `done` or `fault` pulse is visible. Second, a memory acknowledge can come in the very cycle its request first appears. The bench runs operations back to back, so each new `start` is driven on the sampling edge where the previous completion pulse is seen. The memory responder picks a random latency of zero to two cycles. Each result is judged against a model of the table and descriptors that the bench keeps itself. The judge covers the fault kind, the number of accesses, the written descriptor and the notification fields. The bench also pulses `start` in the middle of an operation and checks that the extra pulse leaves no trace.

// File: rtl/uipi_post_seq.sv
module uipi_post_seq #(
  parameter int AW = 64,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] index,
  input  logic [AW-1:0] tbl_base,
  input  logic [IW-1:0] tbl_size,
  input  logic          feat_en,
  input  logic          tt_en,
  input  logic          long_mode,
  input  logic          in_enclave,
  input  logic          apic_x2,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          fault_ud,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [127:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [127:0]  mem_rdata,
  output logic          ipi_valid,
  output logic [7:0]    ipi_vec,
  output logic [31:0]   ipi_dest
);

  localparam int ESH = 4;

  typedef enum logic [1:0] {S_IDLE, S_ENT, S_DSC, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [127:0]  data_q;
  logic [5:0]    uv_q;
  logic          notify_q;
  logic          x2_q;
  logic [127:0]  upd;

  wire ctx_ok  = feat_en && tt_en && long_mode && !in_enclave;
  wire ent_bad = !mem_rdata[0] || (|mem_rdata[7:1]);
  wire dsc_bad = (|mem_rdata[15:2]) || (|mem_rdata[31:24]);
  wire dsc_idle = !mem_rdata[0] && !mem_rdata[1];

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_lock  = (st == S_DSC) || (st == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    upd = mem_rdata;
    upd[7'd64 + {1'b0, uv_q}] = 1'b1;
    if (dsc_idle) upd[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      uv_q      <= '0;
      notify_q  <= 1'b0;
      x2_q      <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      fault_ud  <= 1'b0;
      ipi_valid <= 1'b0;
      ipi_vec   <= '0;
      ipi_dest  <= '0;
    end else begin
      done      <= 1'b0;
      fault     <= 1'b0;
      ipi_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!ctx_ok) begin
            fault    <= 1'b1;
            fault_ud <= 1'b1;
          end else if (index > tbl_size) begin
            fault    <= 1'b1;
            fault_ud <= 1'b0;
          end else begin
            addr_q <= tbl_base + (AW'(index) << ESH);
            x2_q   <= apic_x2;
            st     <= S_ENT;
          end
        end
        S_ENT: if (mem_ack) begin
          if (ent_bad) begin
            fault    <= 1'b1;
            fault_ud <= 1'b0;
            st       <= S_IDLE;
          end else begin
            uv_q   <= mem_rdata[13:8];
            addr_q <= AW'(mem_rdata[127:64]);
            st     <= S_DSC;
          end
        end
        S_DSC: if (mem_ack) begin
          if (dsc_bad) begin
            fault    <= 1'b1;
            fault_ud <= 1'b0;
            st       <= S_IDLE;
          end else begin
            data_q   <= upd;
            notify_q <= dsc_idle;
            st       <= S_WB;
          end
        end
        S_WB: if (mem_ack) begin
          done <= 1'b1;
          st   <= S_IDLE;
          if (notify_q) begin
            ipi_valid <= 1'b1;
            ipi_vec   <= data_q[23:16];
            ipi_dest  <= x2_q ? data_q[63:32] : {24'h0, data_q[47:40]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uipi_post_seq_chk.sv
module uipi_post_seq_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_lock,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          ipi_valid,
  input logic [31:0]   ipi_dest,
  input logic          x2
);

  AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R11

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || done) |=> !(fault || done) || !$past(busy) && !busy); // R11

  AST_IPI_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid |-> done); // R7

  AST_WB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock); // R8

  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_lock && !mem_req)); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3

  AST_SHORT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_valid && !x2) |-> (ipi_dest[31:8] == 24'h0)); // R10

endmodule

bind uipi_post_seq uipi_post_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .ipi_valid(ipi_valid), .ipi_dest(ipi_dest), .x2(x2_q)
);

// File: tb/uipi_post_seq_tb.sv
`timescale 1ns/1ps
module uipi_post_seq_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  index = '0;
  logic [63:0]  tbl_base = 64'h1000;
  logic [15:0]  tbl_size = 16'd10;
  logic         feat_en = 1'b1, tt_en = 1'b1, long_mode = 1'b1, in_enclave = 1'b0;
  logic         apic_x2 = 1'b1;
  logic         busy, done, fault, fault_ud;
  logic         mem_req, mem_we, mem_lock;
  logic [63:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;
  logic         ipi_valid;
  logic [7:0]   ipi_vec;
  logic [31:0]  ipi_dest;

  always #2 clk = ~clk;

  uipi_post_seq dut_i (.*);

  logic [127:0] mem [logic [63:0]];
  int n_chk = 0, n_fail = 0;
  int acc_cnt = 0, wr_cnt = 0, wcnt = 0;
  logic first_lock, dsc_lock, wr_lock;
  logic [63:0] first_addr;

  function automatic logic [127:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 128'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = rd(mem_addr);
          if (acc_cnt == 0) begin first_lock = mem_lock; first_addr = mem_addr; end
          if (acc_cnt == 1) dsc_lock = mem_lock;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_lock = mem_lock;
            wr_cnt++;
          end
          acc_cnt++;
          wcnt = $urandom % 3;
        end else wcnt--;
      end
    end
  end

  function automatic logic [127:0] mk_ent(bit v, logic [6:0] rsv, logic [7:0] uv, logic [63:0] da);
    return {da, 48'h0, uv, rsv, v};
  endfunction

  function automatic logic [127:0] mk_dsc(bit on, bit sn, logic [13:0] r0, logic [7:0] nv,
                                         logic [7:0] r1, logic [31:0] dst, logic [63:0] pir);
    return {pir, dst, r1, nv, r0, sn, on};
  endfunction

  task automatic run_op(input logic [15:0] idx, input bit poke);
    logic [63:0] ea, da;
    logic [127:0] ent, d, nd;
    bit eud, egp, ntf;
    int eacc, cyc;
    logic [7:0] ev;
    logic [31:0] edst;
    eud  = !(feat_en && tt_en && long_mode && !in_enclave);
    ea   = tbl_base + (64'(idx) << 4);
    ent  = rd(ea);
    da   = ent[127:64];
    d    = rd(da);
    nd   = d;
    nd[64 + int'(ent[13:8])] = 1'b1;
    ntf  = !d[0] && !d[1];
    if (ntf) nd[0] = 1'b1;
    ev   = d[23:16];
    edst = apic_x2 ? d[63:32] : {24'h0, d[47:40]};
    egp  = 1'b0;
    eacc = 3;
    if (eud) eacc = 0;
    else if (idx > tbl_size) begin egp = 1'b1; eacc = 0; end
    else if (!ent[0] || (|ent[7:1])) begin egp = 1'b1; eacc = 1; end
    else if ((|d[15:2]) || (|d[31:24])) begin egp = 1'b1; eacc = 2; end
    acc_cnt = 0; wr_cnt = 0;
    index = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    index = 16'($urandom);
    cyc = 0;
    while (!(done || fault) && cyc < 100) begin
      start = (poke && cyc == 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done ^ fault, "R11 one end pulse", {done, fault}, 2'b01 << !(eud || egp));
    chk(fault == (eud || egp), "R1/R2/R4/R5 fault", fault, eud || egp);
    if (eud) chk(fault_ud == 1'b1, "R1 fault kind", fault_ud, 1);
    else if (egp) chk(fault_ud == 1'b0, "R2/R4/R5 fault kind", fault_ud, 0);
    chk(acc_cnt == eacc, "R1/R2/R4/R5 access count", acc_cnt, eacc);
    chk(!mem_lock, "R8 lock released", mem_lock, 0);
    if (eacc > 0) begin
      chk(first_addr == ea, "R3 entry address", first_addr, ea);
      chk(first_lock == 1'b0, "R3 entry unlocked", first_lock, 0);
    end
    if (eacc >= 2) chk(dsc_lock == 1'b1, "R5 descriptor locked", dsc_lock, 1);
    if (!eud && !egp) begin
      chk(wr_cnt == 1 && wr_lock == 1'b1, "R8 locked write-back", {wr_cnt, wr_lock}, 33'h3);
      chk(rd(da) == nd, "R6/R7 written descriptor", rd(da), nd);
      chk(ipi_valid == ntf, "R7 notify", ipi_valid, ntf);
      if (ntf) begin
        chk(ipi_vec == ev, "R9 vector", ipi_vec, ev);
        chk(ipi_dest == edst, apic_x2 ? "R9 dest" : "R10 dest", ipi_dest, edst);
      end
    end else chk(!ipi_valid && wr_cnt == 0, "R5 no write on fault", {ipi_valid, wr_cnt}, 0);
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      chk(!busy && acc_cnt == eacc, "R11 start ignored while busy", {busy, acc_cnt}, eacc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mem[64'h1000 + (64'd0 << 4)]  = mk_ent(1, 0, 8'd5, 64'h8000);
    mem[64'h1000 + (64'd1 << 4)]  = mk_ent(0, 0, 8'd5, 64'h8000);
    mem[64'h1000 + (64'd2 << 4)]  = mk_ent(1, 7'h08, 8'd5, 64'h8000);
    mem[64'h1000 + (64'd3 << 4)]  = mk_ent(1, 0, 8'd63, 64'h8010);
    mem[64'h1000 + (64'd4 << 4)]  = mk_ent(1, 0, 8'd9, 64'h8020);
    mem[64'h1000 + (64'd10 << 4)] = mk_ent(1, 0, 8'd70, 64'h8030);
    mem[64'h8000] = mk_dsc(0, 0, 0, 8'hA5, 0, 32'h1234_5678, 64'h0);
    mem[64'h8010] = mk_dsc(0, 0, 14'h0004, 8'h11, 0, 32'h0, 64'h0);
    mem[64'h8020] = mk_dsc(0, 1, 0, 8'h22, 0, 32'hCAFE_BEEF, 64'h1);
    mem[64'h8030] = mk_dsc(0, 0, 0, 8'h33, 0, 32'h0000_AB00, 64'h0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R11 reset state", {busy, done, fault, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    feat_en = 1'b0; run_op(16'd0, 0); feat_en = 1'b1;          // R1
    in_enclave = 1'b1; run_op(16'd0, 0); in_enclave = 1'b0;    // R1
    run_op(16'd11, 0);                                          // R2
    run_op(16'd1, 0);                                           // R4
    run_op(16'd2, 0);                                           // R4
    run_op(16'd3, 0);                                           // R5
    run_op(16'd0, 1);                                           // R7 R9 R11
    run_op(16'd0, 0);                                           // R7 outstanding set
    run_op(16'd4, 0);                                           // R7 suppressed
    apic_x2 = 1'b0; run_op(16'd10, 0);                          // R2 edge, R10
    for (int i = 0; i < 60; i++) begin
      logic [15:0] ix;
      ix = 16'($urandom % 13);
      apic_x2 = 1'($urandom);
      in_enclave = ($urandom % 16 == 0);
      if ($urandom % 2) begin
        mem[64'h1000 + (64'(ix) << 4)] = mk_ent(($urandom % 8) != 0,
          ($urandom % 8 == 0) ? 7'h40 : 7'h0, 8'($urandom), 64'h8000 + 64'(($urandom % 4) * 16));
      end
      if ($urandom % 3 == 0) begin
        mem[64'h8000 + 64'(($urandom % 4) * 16)] = mk_dsc(($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 8 == 0) ? 14'h0100 : 14'h0, 8'($urandom),
          ($urandom % 8 == 0) ? 8'h01 : 8'h00, $urandom, {$urandom, $urandom});
      end
      run_op(ix, (i % 7) == 3);
    end
    in_enclave = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule